// File: doc/BRIEF.md
# MSI Interrupt Remapping Unit

The block screens and rewrites message-signalled interrupt writes on their way to the interrupt controllers. Each accepted request carries a 32-bit address, a 32-bit data word, a 16-bit requester ID and a flag saying whether the write is 4 bytes wide. The unit asks a device-table lookup port for the 64-bit control word of that requester. It then either forwards the message untouched, rebuilds it from a 32-bit entry of a per-device remapping table, or rejects it with a target-abort flag.

Table entries are read through a single-word memory read port with a request/acknowledge handshake. The unit handles one message at a time. Each result is presented for one cycle on a valid strobe together with abort and unsupported flags. A sticky status bit records that at least one message has been passed or remapped since it was last invalidated. An invalidate-all pulse clears that bit and produces a one-cycle notify pulse.

Control word layout (bit positions used by the block): bit 0 remap enable; bits 2:1 interrupt control (00 abort, 01 pass, 10 remap, 11 reserved); bits 6:3 table size exponent; bit 7 NMI pass; bit 8 INIT pass; bit 9 ExtINT pass; bit 10 LINT0 pass; bit 11 LINT1 pass; bits 63:32 table root byte address. The delivery type is data bits 10:8, with these codes: 000 fixed, 001 arbitrated, 010 SMI, 011 LINT1, 100 NMI, 101 INIT, 110 LINT0, 111 ExtINT. The table index is data bits 7:0.

Top module: `msir_top`

## Requirements
- R1: A write with `req_len4` low gives a target abort (`out_abort`=1) with the original address and data. No device lookup and no table read is issued for it.
- R2: If control bit 0 (remap enable) is clear, the message is output unchanged with abort and unsupported both low. No table read is issued and the status bit is not set.
- R3: With remapping enabled, an index (data[7:0]) of 2^size or more (size = control bits 6:3, any index is in range when size >= 8) gives a target abort for every delivery type, with no table read. A table read, when one is needed, uses address root + index*4.
- R4: For fixed (000) and arbitrated (001) types, interrupt control 01 forwards the message unchanged. Codes 00 and 11 give a target abort without a table read. Code 10 fetches the entry.
- R5: A valid fetched entry produces address 0xFEE00000 with entry bit 6 (destination mode) at address bit 2, entry bit 5 (request-EOI) at address bit 3, and entry bits 15:8 (destination) at address bits 19:12. The data is entry bits 23:16 (vector) in data bits 7:0 and entry bits 4:2 (interrupt type) in data bits 10:8, with all other data bits zero.
- R6: A fetched entry whose bit 0 (valid) is clear gives a target abort, and any target-aborted output carries the original address and data.
- R7: NMI, INIT, ExtINT, LINT0 and LINT1 messages each check their own pass bit (bits 7, 8, 9, 10, 11). A set bit forwards the message unchanged; a clear bit gives a target abort. No table read is issued.
- R8: An in-range SMI message with remapping enabled is forwarded unchanged with `out_unsup`=1 and no abort.
- R9: `remapped_any` becomes 1 in the cycle after an output that was a pass (R4, R7) or a remap (R5). `inval_all` clears it and raises `inval_notify` for the following cycle. A set in the same cycle as an invalidate wins.
- R10: `dev_req` stays high with `dev_id` equal to the requester ID until `dev_ack`. `mem_req` stays high with a stable `mem_addr` until `mem_ack`. `req_ready` is high only when no lookup or read is outstanding.
- R11: `out_valid` is high for the cycle after the edge that completes the last handshake of a message (acceptance for R1, `dev_ack` without a fetch, `mem_ack` otherwise).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Incoming message write present |
| req_ready | output | 1 | Unit idle, request accepted |
| req_addr | input | 32 | Message address |
| req_data | input | 32 | Message data |
| req_rid | input | 16 | Requester ID |
| req_len4 | input | 1 | Write is 4 bytes wide |
| dev_req | output | 1 | Device control lookup request |
| dev_id | output | 16 | Requester ID being looked up |
| dev_ack | input | 1 | Lookup answer valid |
| dev_ctl | input | 64 | Per-device control word |
| mem_req | output | 1 | Table entry read request |
| mem_addr | output | 32 | Table entry byte address |
| mem_ack | input | 1 | Read data valid |
| mem_rdata | input | 32 | Table entry |
| out_valid | output | 1 | Result strobe |
| out_addr | output | 32 | Result address |
| out_data | output | 32 | Result data |
| out_abort | output | 1 | Target abort |
| out_unsup | output | 1 | Unsupported delivery type forwarded |
| inval_all | input | 1 | Invalidate-all pulse |
| inval_notify | output | 1 | Invalidate notification |
| remapped_any | output | 1 | Sticky pass/remap status |

## Verification
A result is due one edge after the last handshake of its message. For a narrow write that is the acceptance edge; otherwise it is the `dev_ack` edge, or the `mem_ack` edge when a table read is needed. The status bit follows one edge after the result strobe. The bench answers each lookup and read after a random 0 to 3 cycle delay that it chooses itself. At every falling edge before the due cycle it checks that the strobe is low and that the expected request is held. It samples the result exactly at the falling edge after the due edge, and the status bit and notify pulse one cycle later.

// File: rtl/msir_pkg.sv
package msir_pkg;

    localparam int MSG_W  = 32;
    localparam int RID_W  = 16;
    localparam int CTL_W  = 64;
    localparam int SIZE_W = 4;
    localparam logic [MSG_W-1:0] LAPIC_BASE = 32'hFEE0_0000;

    typedef enum logic [2:0] {
        DM_FIXED  = 3'b000,
        DM_ARB    = 3'b001,
        DM_SMI    = 3'b010,
        DM_LINT1  = 3'b011,
        DM_NMI    = 3'b100,
        DM_INIT   = 3'b101,
        DM_LINT0  = 3'b110,
        DM_EXTINT = 3'b111
    } dmode_e;

    typedef enum logic [1:0] {
        IC_ABORT = 2'b00,
        IC_PASS  = 2'b01,
        IC_REMAP = 2'b10,
        IC_RSVD  = 2'b11
    } ictl_e;

    typedef struct packed {
        logic [31:0]       root;
        logic [19:0]       rsvd;
        logic              lint1_ok;
        logic              lint0_ok;
        logic              extint_ok;
        logic              init_ok;
        logic              nmi_ok;
        logic [SIZE_W-1:0] size_exp;
        ictl_e             ictl;
        logic              remap_en;
    } devctl_t;

    typedef struct packed {
        logic [7:0] rsvd_hi;
        logic [7:0] vector;
        logic [7:0] dest;
        logic       rsvd_lo;
        logic       dst_mode;
        logic       req_eoi;
        logic [2:0] itype;
        logic       no_fault;
        logic       valid;
    } entry_t;

    typedef struct packed {
        logic [MSG_W-1:0] addr;
        logic [MSG_W-1:0] data;
    } msg_t;

    typedef enum logic [2:0] {
        ACT_FWD,
        ACT_PASS,
        ACT_FETCH,
        ACT_ABORT,
        ACT_UNSUP
    } act_e;

    function automatic msg_t build_remap(entry_t e);
        msg_t m;
        m.addr = LAPIC_BASE | {12'b0, e.dest, 12'b0}
                            | {28'b0, e.req_eoi, e.dst_mode, 2'b0};
        m.data = {21'b0, e.itype, e.vector};
        return m;
    endfunction

endpackage

// File: rtl/msir_bound.sv
module msir_bound
    import msir_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic [IDX_W-1:0]  idx,
    input  logic [SIZE_W-1:0] size_exp,
    input  logic [31:0]       root,
    output logic              in_range,
    output logic [31:0]       fetch_addr
);
    always_comb begin
        if (32'(size_exp) >= IDX_W) begin
            in_range = 1'b1;
        end else begin
            in_range = ((idx >> size_exp) == '0);
        end
        fetch_addr = root + (32'(idx) << 2);
    end
endmodule

// File: rtl/msir_dispatch.sv
module msir_dispatch
    import msir_pkg::*;
(
    input  devctl_t ctl,
    input  dmode_e  dmode,
    input  logic    in_range,
    output act_e    act
);
    function automatic act_e gate(logic ok);
        return ok ? ACT_PASS : ACT_ABORT;
    endfunction

    always_comb begin
        if (!ctl.remap_en) begin
            act = ACT_FWD;
        end else if (!in_range) begin
            act = ACT_ABORT;
        end else begin
            unique case (dmode)
                DM_FIXED, DM_ARB: begin
                    unique case (ctl.ictl)
                        IC_PASS:  act = ACT_PASS;
                        IC_REMAP: act = ACT_FETCH;
                        default:  act = ACT_ABORT;
                    endcase
                end
                DM_SMI:    act = ACT_UNSUP;
                DM_NMI:    act = gate(ctl.nmi_ok);
                DM_INIT:   act = gate(ctl.init_ok);
                DM_EXTINT: act = gate(ctl.extint_ok);
                DM_LINT0:  act = gate(ctl.lint0_ok);
                DM_LINT1:  act = gate(ctl.lint1_ok);
                default:   act = ACT_ABORT;
            endcase
        end
    end
endmodule

// File: rtl/msir_status.sv
module msir_status (
    input  logic clk,
    input  logic rst,
    input  logic set_pulse,
    input  logic inval_all,
    output logic remapped_any,
    output logic inval_notify
);
    always_ff @(posedge clk) begin
        if (rst) begin
            remapped_any <= 1'b0;
            inval_notify <= 1'b0;
        end else begin
            remapped_any <= (remapped_any & ~inval_all) | set_pulse;
            inval_notify <= inval_all;
        end
    end
endmodule

// File: rtl/msir_top.sv
module msir_top
    import msir_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [MSG_W-1:0] req_addr,
    input  logic [MSG_W-1:0] req_data,
    input  logic [RID_W-1:0] req_rid,
    input  logic             req_len4,
    output logic             dev_req,
    output logic [RID_W-1:0] dev_id,
    input  logic             dev_ack,
    input  logic [CTL_W-1:0] dev_ctl,
    output logic             mem_req,
    output logic [31:0]      mem_addr,
    input  logic             mem_ack,
    input  logic [31:0]      mem_rdata,
    output logic             out_valid,
    output logic [MSG_W-1:0] out_addr,
    output logic [MSG_W-1:0] out_data,
    output logic             out_abort,
    output logic             out_unsup,
    input  logic             inval_all,
    output logic             inval_notify,
    output logic             remapped_any
);
    typedef enum logic [1:0] {S_IDLE, S_DEV, S_MEM} state_e;

    state_e           state;
    msg_t             msg_q;
    logic [RID_W-1:0] rid_q;
    logic [31:0]      faddr_q;
    msg_t             out_q;
    logic             stat_set_q;

    devctl_t          ctl;
    logic             in_range;
    logic [31:0]      fetch_addr;
    act_e             act;
    entry_t           entry;

    assign ctl   = devctl_t'(dev_ctl);
    assign entry = entry_t'(mem_rdata);

    msir_bound #(.IDX_W(IDX_W)) i_bound (
        .idx        (msg_q.data[IDX_W-1:0]),
        .size_exp   (ctl.size_exp),
        .root       (ctl.root),
        .in_range   (in_range),
        .fetch_addr (fetch_addr)
    );

    msir_dispatch i_dispatch (
        .ctl      (ctl),
        .dmode    (dmode_e'(msg_q.data[10:8])),
        .in_range (in_range),
        .act      (act)
    );

    msir_status i_status (
        .clk          (clk),
        .rst          (rst),
        .set_pulse    (out_valid & stat_set_q),
        .inval_all    (inval_all),
        .remapped_any (remapped_any),
        .inval_notify (inval_notify)
    );

    assign req_ready = (state == S_IDLE);
    assign dev_req   = (state == S_DEV);
    assign dev_id    = rid_q;
    assign mem_req   = (state == S_MEM);
    assign mem_addr  = faddr_q;
    assign out_addr  = out_q.addr;
    assign out_data  = out_q.data;

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= S_IDLE;
            msg_q      <= '0;
            rid_q      <= '0;
            faddr_q    <= '0;
            out_q      <= '0;
            out_valid  <= 1'b0;
            out_abort  <= 1'b0;
            out_unsup  <= 1'b0;
            stat_set_q <= 1'b0;
        end else begin
            out_valid  <= 1'b0;
            stat_set_q <= 1'b0;
            unique case (state)
                S_IDLE: begin
                    if (req_valid) begin
                        msg_q <= '{addr: req_addr, data: req_data};
                        rid_q <= req_rid;
                        if (req_len4) begin
                            state <= S_DEV;
                        end else begin
                            out_valid <= 1'b1;
                            out_q     <= '{addr: req_addr, data: req_data};
                            out_abort <= 1'b1;
                            out_unsup <= 1'b0;
                        end
                    end
                end
                S_DEV: begin
                    if (dev_ack) begin
                        faddr_q <= fetch_addr;
                        if (act == ACT_FETCH) begin
                            state <= S_MEM;
                        end else begin
                            state      <= S_IDLE;
                            out_valid  <= 1'b1;
                            out_q      <= msg_q;
                            out_abort  <= (act == ACT_ABORT);
                            out_unsup  <= (act == ACT_UNSUP);
                            stat_set_q <= (act == ACT_PASS);
                        end
                    end
                end
                S_MEM: begin
                    if (mem_ack) begin
                        state      <= S_IDLE;
                        out_valid  <= 1'b1;
                        out_unsup  <= 1'b0;
                        out_abort  <= !entry.valid;
                        stat_set_q <= entry.valid;
                        out_q      <= entry.valid ? build_remap(entry) : msg_q;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/msir_chk.sv
module msir_chk (
    input logic        clk,
    input logic        rst,
    input logic        req_ready,
    input logic        dev_req,
    input logic        dev_ack,
    input logic        mem_req,
    input logic        mem_ack,
    input logic [31:0] mem_addr,
    input logic        out_valid,
    input logic [31:0] out_addr,
    input logic [31:0] out_data,
    input logic        out_abort,
    input logic        out_unsup,
    input logic        inval_all,
    input logic        inval_notify,
    input logic        remapped_any,
    input logic        stat_set_q
);
    p_hold_dev_r10: assert property (@(posedge clk) disable iff (rst)
        dev_req && !dev_ack |=> dev_req);

    p_hold_mem_r10: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr));

    p_ready_idle_r10: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> !dev_req && !mem_req);

    p_notify_r9: assert property (@(posedge clk) disable iff (rst)
        inval_all |=> inval_notify);

    p_clear_r9: assert property (@(posedge clk) disable iff (rst)
        inval_all && !(out_valid && stat_set_q) |=> !remapped_any);

    p_unsup_no_abort_r8: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_unsup |-> !out_abort);

    p_remap_shape_r5: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_abort && $past(mem_req && mem_ack)
        |-> out_addr[31:20] == 12'hFEE && out_data[31:11] == 21'b0);

    p_abort_no_status_r6: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_abort |-> !stat_set_q);
endmodule

bind msir_top msir_chk i_chk (
    .clk          (clk),
    .rst          (rst),
    .req_ready    (req_ready),
    .dev_req      (dev_req),
    .dev_ack      (dev_ack),
    .mem_req      (mem_req),
    .mem_ack      (mem_ack),
    .mem_addr     (mem_addr),
    .out_valid    (out_valid),
    .out_addr     (out_addr),
    .out_data     (out_data),
    .out_abort    (out_abort),
    .out_unsup    (out_unsup),
    .inval_all    (inval_all),
    .inval_notify (inval_notify),
    .remapped_any (remapped_any),
    .stat_set_q   (stat_set_q)
);

// File: tb/test_msir_top.sv
module test_msir_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic [31:0] req_data = '0;
    logic [15:0] req_rid = '0;
    logic        req_len4 = 1'b0;
    logic        dev_req;
    logic [15:0] dev_id;
    logic        dev_ack = 1'b0;
    logic [63:0] dev_ctl = '0;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        out_valid;
    logic [31:0] out_addr;
    logic [31:0] out_data;
    logic        out_abort;
    logic        out_unsup;
    logic        inval_all = 1'b0;
    logic        inval_notify;
    logic        remapped_any;

    int checks = 0;
    int fails  = 0;
    bit status_model = 1'b0;

    always #5 clk = ~clk;

    msir_top i_msir_top (.*);

    typedef struct {
        bit        abort;
        bit        unsup;
        bit        lookup;
        bit        fetch;
        bit        stat;
        bit [31:0] addr;
        bit [31:0] data;
        bit [31:0] faddr;
    } exp_t;

    task automatic chk(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic bit [63:0] mk_ctl(bit [31:0] root, bit [4:0] pass,
                                         bit [3:0] sz, bit [1:0] ic, bit en);
        return {root, 20'b0, pass, sz, ic, en};
    endfunction

    function automatic exp_t model(bit l4, bit [63:0] c, bit [31:0] a,
                                   bit [31:0] d, bit [31:0] ent);
        exp_t r;
        bit ok;
        r.abort = 0; r.unsup = 0; r.lookup = 0; r.fetch = 0; r.stat = 0;
        r.addr = a; r.data = d;
        r.faddr = c[63:32] + {22'b0, d[7:0], 2'b0};
        if (!l4) begin r.abort = 1; return r; end
        r.lookup = 1;
        if (!c[0]) return r;
        if (c[6:3] < 8 && (d[7:0] >> c[6:3]) != 0) begin r.abort = 1; return r; end
        ok = 0;
        case (d[10:8])
            3'd0, 3'd1: begin
                if (c[2:1] == 2'b01) begin r.stat = 1; return r; end
                if (c[2:1] != 2'b10) begin r.abort = 1; return r; end
                r.fetch = 1;
                if (ent[0]) begin
                    r.addr = 32'hFEE0_0000 | ({24'b0, ent[15:8]} << 12)
                           | ({31'b0, ent[5]} << 3) | ({31'b0, ent[6]} << 2);
                    r.data = {21'b0, ent[4:2], ent[23:16]};
                    r.stat = 1;
                end else r.abort = 1;
                return r;
            end
            3'd2: begin r.unsup = 1; return r; end
            3'd4: ok = c[7];
            3'd5: ok = c[8];
            3'd7: ok = c[9];
            3'd6: ok = c[10];
            default: ok = c[11];
        endcase
        if (ok) r.stat = 1; else r.abort = 1;
        return r;
    endfunction

    task automatic run(input bit [31:0] a, input bit [31:0] d, input bit [15:0] rid,
                       input bit l4, input bit [63:0] c, input bit [31:0] ent,
                       input int dl, input int ml, input bit inv, input string tag);
        exp_t e;
        e = model(l4, c, a, d, ent);
        @(negedge clk);
        chk("R10", "req_ready idle", req_ready, 1);
        req_valid = 1; req_addr = a; req_data = d; req_rid = rid; req_len4 = l4;
        @(posedge clk);
        @(negedge clk);
        req_valid = 0;
        if (e.lookup) begin
            for (int i = 0; i < dl; i++) begin
                chk("R10", "dev_req held", {dev_req, out_valid}, 2'b10);
                @(posedge clk); @(negedge clk);
            end
            chk("R10", "dev_req/dev_id", {dev_req, dev_id}, {1'b1, rid});
            dev_ack = 1; dev_ctl = c;
            @(posedge clk); @(negedge clk);
            dev_ack = 0;
            if (e.fetch) begin
                for (int i = 0; i < ml; i++) begin
                    chk("R10", "mem_req held", {mem_req, out_valid}, 2'b10);
                    @(posedge clk); @(negedge clk);
                end
                chk("R3", "mem_req/mem_addr", {mem_req, mem_addr}, {1'b1, e.faddr});
                mem_ack = 1; mem_rdata = ent;
                @(posedge clk); @(negedge clk);
                mem_ack = 0;
            end
        end
        chk("R11", "out_valid due", out_valid, 1);
        chk(tag, "abort/unsup", {out_abort, out_unsup}, {e.abort, e.unsup});
        chk(tag, "addr/data", {out_addr, out_data}, {e.addr, e.data});
        chk("R3", "no stray read", mem_req, 0);
        if (inv) inval_all = 1;
        status_model = e.stat ? 1'b1 : (inv ? 1'b0 : status_model);
        @(posedge clk); @(negedge clk);
        inval_all = 0;
        chk("R9", "remapped_any", remapped_any, status_model);
        chk("R9", "inval_notify", inval_notify, inv);
        chk("R11", "single strobe", out_valid, 0);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin : main
        bit [31:0] seed;
        seed = $urandom(32'd1207);
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R10", "reset outputs", {req_ready, dev_req, mem_req, out_valid, remapped_any, inval_notify}, 6'b100000);
        rst = 0;

        // R1 narrow write
        run(32'hFEE0_1000, 32'h0000_0041, 16'h0101, 0, mk_ctl(32'h1000, 5'h1F, 4'd8, 2'b01, 1), 0, 0, 0, 0, "R1");
        // R2 remap disabled, even SMI and out of range
        run(32'hFEE0_2000, 32'h0000_02FF, 16'h0202, 1, mk_ctl(32'h1000, 0, 4'd0, 2'b00, 0), 0, 2, 0, 0, "R2");
        // R4 pass on fixed
        run(32'hFEE0_3004, 32'h0000_0003, 16'h0303, 1, mk_ctl(32'h2000, 0, 4'd2, 2'b01, 1), 0, 1, 0, 0, "R4");
        // R9 invalidate in an idle-status window
        run(32'hFEE0_3004, 32'h0000_0003, 16'h0303, 1, mk_ctl(32'h2000, 0, 4'd2, 2'b00, 1), 0, 0, 0, 1, "R4");
        // R4 reserved control
        run(32'hFEE0_3004, 32'h0000_0103, 16'h0303, 1, mk_ctl(32'h2000, 0, 4'd2, 2'b11, 1), 0, 0, 0, 0, "R4");
        // R3 bound edge: size 3, index 7 in range, index 8 aborts
        run(32'hFEE0_0000, 32'h0000_0007, 16'h0404, 1, mk_ctl(32'h0008_0000, 0, 4'd3, 2'b10, 1), 32'h00A5_3B6D, 0, 2, 0, "R5");
        run(32'hFEE0_0000, 32'h0000_0008, 16'h0404, 1, mk_ctl(32'h0008_0000, 5'h1F, 4'd3, 2'b10, 1), 32'h00A5_3B6D, 0, 0, 0, "R3");
        // R3 size >= index width: index 255 in range
        run(32'hFEE0_0000, 32'h0000_01FF, 16'h0505, 1, mk_ctl(32'h0010_0000, 0, 4'd12, 2'b10, 1), 32'hFF77_FF7D, 3, 3, 0, "R5");
        // R6 invalid entry, with invalidate in the strobe cycle
        run(32'hFEE0_0000, 32'h0000_0001, 16'h0606, 1, mk_ctl(32'h0020_0000, 0, 4'd1, 2'b10, 1), 32'h0012_3400, 0, 1, 1, "R6");
        // R9 set wins over simultaneous invalidate
        run(32'hFEE0_0000, 32'h0000_0002, 16'h0606, 1, mk_ctl(32'h0020_0000, 0, 4'd4, 2'b10, 1), 32'h0012_3401, 1, 0, 1, "R9");
        // R7 system types, pass and block
        for (int t = 3; t < 8; t++) begin
            run(32'hFEE0_0000, {21'b0, 3'(t), 8'h00}, 16'h0700, 1, mk_ctl(32'h0, 5'h1F, 4'd0, 2'b00, 1), 0, 0, 0, 0, "R7");
            run(32'hFEE0_0000, {21'b0, 3'(t), 8'h00}, 16'h0701, 1, mk_ctl(32'h0, 5'h00, 4'd0, 2'b01, 1), 0, 0, 0, 0, "R7");
        end
        // R8 SMI
        run(32'hFEE0_0000, 32'h0000_0200, 16'h0808, 1, mk_ctl(32'h0, 5'h1F, 4'd0, 2'b01, 1), 0, 0, 0, 0, "R8");

        // constrained random mix
        for (int n = 0; n < 300; n++) begin
            bit [63:0] c;
            bit [31:0] d;
            c = mk_ctl($urandom & 32'hFFFF_FFFC, 5'($urandom), 4'($urandom % 10),
                       2'($urandom), ($urandom % 8) != 0);
            d = {21'b0, 3'($urandom), 8'($urandom)};
            run(32'hFEE0_0000 | ($urandom & 32'h000F_FFFC), d, 16'($urandom),
                ($urandom % 16) != 0, c, $urandom, int'($urandom % 4), int'($urandom % 4),
                ($urandom % 10) == 0, "R5");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule